// File: doc/BRIEF.md
# Shared RAM Access Breakpoint Unit

This block watches the parameter RAM bus of a microengine and the writes to its channel-select register, and asks the halt logic to stop the engine when a programmed condition occurs. It compares each RAM access against a programmed address. It can narrow the match to writes only or to reads only, and it can also require the write data to equal a programmed value. A second, independent source fires when microcode writes the channel-select register. Writes to that register that come from the scheduler's time-slot changes never fire it.

A match produces a registered one-cycle halt request. No request is issued while the engine is already halted. A sticky two-bit status shows which source or sources caused the latest request, and a debug-port strobe clears it.

The block only observes the bus. It never stalls the bus and has no handshake. The configuration inputs are plain levels held by debug-port registers outside this block.

Top module: `ram_bkpt_unit`

## Requirements
- R1: A RAM match needs `bus_addr` equal to `cfg_addr`. Any other address never matches, whatever the other settings are.
- R2: `cfg_mode` selects the direction. 2'b00 matches writes only (`bus_wr`). 2'b01 matches reads only (`bus_rd`). 2'b10 and 2'b11 match either strobe.
- R3: With `cfg_dq_en` = 1, a write matches only when `bus_wdata` equals `cfg_wdata`.
- R4: With `cfg_dq_en` = 1, a cycle with `bus_wr` = 0 never produces a RAM match, in any mode.
- R5: The channel source matches when `chan_wr` = 1 and `chan_by_ucode` = 1. A write with `chan_by_ucode` = 0 (a time-slot change) has no effect.
- R6: `cfg_ram_en` = 0 disables the RAM source. `cfg_chan_en` = 0 disables the channel source.
- R7: `halt_req` goes high in the cycle after a matching cycle and stays high for one cycle. A match that occurs while `halt_req` is high issues no further request.
- R8: No request is issued for a match in a cycle where `engine_halted` = 1.
- R9: When a request is issued, `hit_status` is loaded with bit 0 = RAM source matched and bit 1 = channel source matched. At all other times it holds its value.
- R10: `status_clr` = 1 clears `hit_status` on the next edge. If a request is issued in the same cycle, the new status wins.
- R11: After reset, `halt_req` = 0 and `hit_status` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ram_en | input | 1 | Enables the RAM source |
| cfg_chan_en | input | 1 | Enables the channel-register source |
| cfg_mode | input | 2 | Direction select (see R2) |
| cfg_dq_en | input | 1 | Requires write data to match |
| cfg_addr | input | AW | Match address |
| cfg_wdata | input | DW | Match write data |
| bus_addr | input | AW | RAM access address |
| bus_wdata | input | DW | RAM write data |
| bus_rd | input | 1 | RAM read strobe |
| bus_wr | input | 1 | RAM write strobe |
| chan_wr | input | 1 | Channel-select register write strobe |
| chan_by_ucode | input | 1 | 1: write made by microcode, 0: by a time-slot change |
| engine_halted | input | 1 | Engine is already halted |
| status_clr | input | 1 | Clears the sticky status |
| halt_req | output | 1 | One-cycle halt request |
| hit_status | output | 2 | Sticky source of the latest request |

## Verification
The bench goes after reads while data qualification is on. A design that forgot R4 would halt on a read of the watched address. It also drives time-slot channel writes, which a careless design would treat as a breakpoint. Back-to-back matches test R7: a design without the pending-request guard would hold `halt_req` high for several cycles. Matches during halt, and a clear that coincides with a new request, test R8 and R10. A wrong priority there would either let a request escape or lose the new status.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    DIR_WRITE  = 2'b00,
    DIR_READ   = 2'b01,
    DIR_ANY    = 2'b10,
    DIR_ANY_B  = 2'b11
  } dir_sel_e;

  localparam int unsigned SRC_W   = 2;
  localparam int unsigned SRC_RAM = 0;
  localparam int unsigned SRC_CH  = 1;
endpackage

// File: rtl/ram_match.sv
module ram_match #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic          dq_en,
  input  logic [AW-1:0] ref_addr,
  input  logic [DW-1:0] ref_data,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          rd,
  input  logic          wr,
  output logic          hit
);
  import bkpt_pkg::*;

  logic addr_eq, dir_ok, data_ok;
  dir_sel_e sel;

  assign sel     = dir_sel_e'(mode);
  assign addr_eq = (addr == ref_addr);
  assign data_ok = !dq_en || (wr && (wdata == ref_data));

  always_comb begin
    unique case (sel)
      DIR_WRITE: dir_ok = wr;
      DIR_READ:  dir_ok = rd;
      default:   dir_ok = rd || wr;
    endcase
  end

  assign hit = en && addr_eq && dir_ok && data_ok;

  // R4
  dq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dq_en) |-> wr);
  // R1
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != ref_addr) |-> !hit);
endmodule

// File: rtl/chan_match.sv
module chan_match (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic chan_wr,
  input  logic by_ucode,
  output logic hit
);
  assign hit = en && chan_wr && by_ucode;

  // R5
  slot_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr && !by_ucode) |-> !hit);
endmodule

// File: rtl/hit_arbiter.sv
module hit_arbiter
  import bkpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_hit,
  input  logic             halted,
  input  logic             clr,
  output logic             req,
  output logic [SRC_W-1:0] status
);
  logic issue;

  assign issue = (|src_hit) && !halted && !req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req    <= 1'b0;
      status <= '0;
    end else begin
      req <= issue;
      if (issue)    status <= src_hit;
      else if (clr) status <= '0;
    end
  end

  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R8
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> !$past(halted));
  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (status != '0));
  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !issue) |=> (status == '0));
endmodule

// File: rtl/ram_bkpt_unit.sv
module ram_bkpt_unit #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ram_en,
  input  logic          cfg_chan_en,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_dq_en,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic          chan_wr,
  input  logic          chan_by_ucode,
  input  logic          engine_halted,
  input  logic          status_clr,
  output logic          halt_req,
  output logic [1:0]    hit_status
);
  import bkpt_pkg::*;

  logic [SRC_W-1:0] src_hit;

  ram_match #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .rst_n(rst_n), .en(cfg_ram_en), .mode(cfg_mode),
    .dq_en(cfg_dq_en), .ref_addr(cfg_addr), .ref_data(cfg_wdata),
    .addr(bus_addr), .wdata(bus_wdata), .rd(bus_rd), .wr(bus_wr),
    .hit(src_hit[SRC_RAM])
  );

  chan_match u_chan (
    .clk(clk), .rst_n(rst_n), .en(cfg_chan_en), .chan_wr(chan_wr),
    .by_ucode(chan_by_ucode), .hit(src_hit[SRC_CH])
  );

  hit_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .src_hit(src_hit), .halted(engine_halted),
    .clr(status_clr), .req(halt_req), .status(hit_status)
  );

  // R6
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ram_en && !cfg_chan_en) |=> !$rose(halt_req));
endmodule

// File: tb/ram_bkpt_unit_tb.sv
module ram_bkpt_unit_tb_top;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ram_en, cfg_chan_en, cfg_dq_en;
  logic [1:0] cfg_mode;
  logic [AW-1:0] cfg_addr, bus_addr;
  logic [DW-1:0] cfg_wdata, bus_wdata;
  logic bus_rd, bus_wr, chan_wr, chan_by_ucode, engine_halted, status_clr;
  logic halt_req;
  logic [1:0] hit_status;

  int checks = 0, errors = 0;
  logic exp_req = 1'b0;
  logic [1:0] exp_st = 2'b00;
  bit done = 0;

  always #4 clk = ~clk;

  ram_bkpt_unit #(.AW(AW), .DW(DW)) dut_i (.*);

  function automatic logic ram_model();
    logic dir;
    case (cfg_mode)
      2'b00: dir = bus_wr;
      2'b01: dir = bus_rd;
      default: dir = bus_rd | bus_wr;
    endcase
    return cfg_ram_en && (bus_addr == cfg_addr) && dir &&
           (!cfg_dq_en || (bus_wr && bus_wdata == cfg_wdata));
  endfunction

  function automatic logic chan_model();
    return cfg_chan_en && chan_wr && chan_by_ucode;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (halt_req !== exp_req || hit_status !== exp_st) begin
      errors++;
      $display("FAIL %s: halt_req=%b status=%b expected halt_req=%b status=%b",
               tag, halt_req, hit_status, exp_req, exp_st);
    end
  endtask

  // inputs are set at a negedge; one clock later the outputs are compared
  task automatic cycle(input string tag);
    logic [1:0] src;
    logic issue;
    src   = {chan_model(), ram_model()};
    issue = (src != 2'b00) && !engine_halted && !exp_req;
    @(posedge clk);
    @(negedge clk);
    exp_req = issue;
    if (issue) exp_st = src;
    else if (status_clr) exp_st = 2'b00;
    check(tag);
  endtask

  task automatic idle();
    bus_rd = 0; bus_wr = 0; chan_wr = 0; chan_by_ucode = 0;
    engine_halted = 0; status_clr = 0;
  endtask

  task automatic ram_acc(input logic rd, input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input string tag);
    idle();
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    cycle(tag);
    idle();
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cfg_ram_en = 1; cfg_chan_en = 1; cfg_dq_en = 0; cfg_mode = 2'b00;
    cfg_addr = 12'h1A4; cfg_wdata = 24'hC0FFEE;
    bus_addr = '0; bus_wdata = '0;
    idle();
    @(negedge clk); @(negedge clk);
    check("R11 reset");
    rst_n = 1;
    @(negedge clk);
    check("R11 after reset");

    // R2 write-only mode
    ram_acc(1, 0, 12'h1A4, 0, "R2 read ignored in write mode");
    ram_acc(0, 1, 12'h1A4, 5, "R2 write hits in write mode");
    // R1 address mismatch
    ram_acc(0, 1, 12'h1A5, 5, "R1 other address");
    cfg_mode = 2'b01;
    ram_acc(0, 1, 12'h1A4, 5, "R2 write ignored in read mode");
    ram_acc(1, 0, 12'h1A4, 5, "R2 read hits in read mode");
    cfg_mode = 2'b11;
    ram_acc(1, 0, 12'h1A4, 5, "R2 either mode read");
    // R3 / R4 data qualification
    cfg_dq_en = 1; cfg_mode = 2'b10;
    ram_acc(0, 1, 12'h1A4, 24'hC0FFEF, "R3 data mismatch");
    ram_acc(0, 1, 12'h1A4, 24'hC0FFEE, "R3 data match");
    ram_acc(1, 0, 12'h1A4, 24'hC0FFEE, "R4 read with data qualify");
    cfg_dq_en = 0;
    // R10 clear
    idle(); status_clr = 1; cycle("R10 clear"); idle(); cycle("R10 clear held");
    // R5 slot transition vs microcode
    idle(); chan_wr = 1; chan_by_ucode = 0; cycle("R5 slot write ignored");
    idle(); cycle("R5 slot write ignored");
    idle(); chan_wr = 1; chan_by_ucode = 1; cycle("R5 microcode write hits");
    idle(); cycle("R5 pulse ends");
    // R9 both sources in one cycle
    idle(); chan_wr = 1; chan_by_ucode = 1; bus_wr = 1; bus_addr = 12'h1A4;
    cycle("R9 both sources"); idle(); cycle("R9 both held");
    // R6 enables
    cfg_ram_en = 0; cfg_chan_en = 0;
    idle(); chan_wr = 1; chan_by_ucode = 1; bus_wr = 1; cycle("R6 disabled");
    idle(); cycle("R6 disabled");
    cfg_ram_en = 1; cfg_chan_en = 1;
    // R7 back-to-back matches
    idle(); bus_wr = 1; bus_addr = 12'h1A4;
    cycle("R7 first"); cycle("R7 second"); cycle("R7 third");
    idle(); cycle("R7 end");
    // R8 halted
    idle(); engine_halted = 1; bus_wr = 1; cycle("R8 halted"); idle(); cycle("R8 halted");
    // R10 clear coincident with a new request
    idle(); status_clr = 1; chan_wr = 1; chan_by_ucode = 1;
    cycle("R10 new hit wins"); idle(); cycle("R10 new hit wins");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) begin
        cfg_ram_en = $urandom_range(0, 3) != 0;
        cfg_chan_en = $urandom_range(0, 3) != 0;
        cfg_mode = 2'($urandom_range(0, 3));
        cfg_dq_en = $urandom_range(0, 1);
        cfg_addr = 12'($urandom);
        cfg_wdata = 24'($urandom_range(0, 3));
      end
      bus_addr = ($urandom_range(0, 1) != 0) ? cfg_addr : 12'($urandom);
      bus_wdata = 24'($urandom_range(0, 3));
      bus_rd = $urandom_range(0, 2) == 0;
      bus_wr = $urandom_range(0, 2) == 0;
      chan_wr = $urandom_range(0, 4) == 0;
      chan_by_ucode = $urandom_range(0, 1);
      engine_halted = $urandom_range(0, 5) == 0;
      status_clr = $urandom_range(0, 7) == 0;
      cycle("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule